// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block sits between fetch and decode in a small 32-bit RISC core. A fetch word can carry a compressed pack of short instructions, each given as a 5-bit index into a 32-entry instruction store. The sequencer accepts one such word and issues the referenced store entries one per cycle, in slot order. Alongside each issued instruction it supplies the immediate that goes with it.

Every store entry keeps a default immediate and a flag that marks it as a branch. Some layouts give up field positions to carry parameters. A parameter bound to an ordinary entry selects a value from a separate 32-entry immediate table. A parameter bound to a branch entry is itself the branch displacement.

The pipeline reports completed instructions back to the block. The block keeps the word until every issued slot has completed, so an exception can rewind issue to the first slot that has not completed. A stall holds issue and a flush abandons the word. Both the instruction store and the immediate table are loaded through plain write ports.

Top module: `pack_slot_seq`

## Requirements
- R1: The fetch word is split into fields: bits 31:26 are the layout code, and the slot fields are A=25:21, B=20:16, C=15:11, D=10:6 and E=4:0. Bit 5 is the binding flag. The layout codes are:
  - 0x20: five slots A..E.
  - 0x21: four slots A..D.
  - 0x22: three slots A..C.
  - 0x23: two slots A,B.
  - 0x24: four slots A..D, with E as parameter 1.
  - 0x25: three slots, with D as parameter 1.
  - 0x26: three slots, with D as parameter 1 and E as parameter 2.
  - 0x27: two slots, with D as parameter 1.
  - 0x28: two slots, with D as parameter 1 and E as parameter 2.
  - Any other code carries no slots.
- R2: A word is accepted on a clock edge where `fetch_valid` and `ready` are both high. From the next cycle, one slot issues per unstalled cycle in slot order. Each issue presents the store entry with `iss_slot` counting from 0.
- R3: Issue ends at the first slot whose index is 0, or after the layout's last slot. A word with no issuable slot is consumed, and `ready` stays high.
- R4: Parameter 1 binds to slot 1 when the flag is 1 and to slot 0 when it is 0. Parameter 2 binds to slot 2 in the three-slot layout. In the two-slot layout it binds to whichever slot parameter 1 does not use.
- R5: When a parameter is bound to a non-branch entry, the issued immediate is the immediate-table value at the parameter's index.
- R6: When a parameter is bound to a branch entry, the issued immediate is the parameter sign-extended, giving a range of -16..+15.
- R7: A slot with no bound parameter issues the entry's default immediate.
- R8: While `stall` is high, no slot issues and the slot pointer holds.
- R9: A `flush` drops the word and its remaining slots, and `ready` is high in the next cycle.
- R10: `done_cnt` counts `commit` pulses for issued slots and never exceeds the number issued. `ready` returns once `done_cnt` reaches the word's issuable slot count.
- R11: A `trap` rewinds issue to slot `done_cnt`. The slot presented in the trap cycle does not count as issued.
- R12: A write through either write port takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Packed word offered |
| fetch_word | input | 32 | Packed word |
| ready | output | 1 | Block can accept a word |
| stall | input | 1 | Hold issue |
| flush | input | 1 | Abandon current word |
| commit | input | 1 | One issued slot completed |
| trap | input | 1 | Exception: rewind to first uncompleted slot |
| iss_valid | output | 1 | Slot issued this cycle |
| iss_instr | output | XLEN | Issued store entry |
| iss_imm | output | XLEN | Immediate for the issued entry |
| iss_slot | output | 3 | Slot number being issued |
| done_cnt | output | 3 | Completed slots of current word |
| ent_we | input | 1 | Store entry write |
| ent_idx | input | 5 | Store entry index |
| ent_instr | input | XLEN | Entry instruction |
| ent_imm | input | XLEN | Entry default immediate |
| ent_branch | input | 1 | Entry is a branch |
| tab_we | input | 1 | Immediate table write |
| tab_idx | input | 5 | Immediate table index |
| tab_val | input | XLEN | Immediate table value |

## Verification
The issue outputs are combinational from registered state and the `stall` input. A word accepted at an edge therefore shows its first slot in the following cycle. `ready`, `done_cnt` and the slot pointer move one edge after the `commit`, `trap` or `flush` that caused them. The bench sets inputs after the falling edge and compares every output with its reference model shortly after. It only then advances the model across the rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pks_pkg.sv
package pks_pkg;
  localparam int FW    = 5;   // slot field width
  localparam int NSLOT = 5;   // slot positions in a word
  localparam int CW    = 3;   // width of slot counters

  localparam logic [5:0] OP_S5    = 6'h20;
  localparam logic [5:0] OP_S4    = 6'h21;
  localparam logic [5:0] OP_S3    = 6'h22;
  localparam logic [5:0] OP_S2    = 6'h23;
  localparam logic [5:0] OP_S4P1  = 6'h24;
  localparam logic [5:0] OP_S3P1  = 6'h25;
  localparam logic [5:0] OP_S3P2  = 6'h26;
  localparam logic [5:0] OP_S2P1  = 6'h27;
  localparam logic [5:0] OP_S2P2  = 6'h28;

  typedef struct packed {
    logic          hit;
    logic [FW-1:0] val;
  } pbind_t;

  function automatic logic [CW-1:0] layout_len(input logic [5:0] op);
    case (op)
      OP_S5:                    return CW'(5);
      OP_S4, OP_S4P1:           return CW'(4);
      OP_S3, OP_S3P1, OP_S3P2:  return CW'(3);
      OP_S2, OP_S2P1, OP_S2P2:  return CW'(2);
      default:                  return '0;
    endcase
  endfunction

  function automatic logic [FW-1:0] slot_field(input logic [31:0] w, input logic [CW-1:0] k);
    case (k)
      3'd0:    return w[25:21];
      3'd1:    return w[20:16];
      3'd2:    return w[15:11];
      3'd3:    return w[10:6];
      3'd4:    return w[4:0];
      default: return '0;
    endcase
  endfunction

  // number of slots issued before the first empty index or the layout end
  function automatic logic [CW-1:0] eff_len(input logic [31:0] w);
    logic [CW-1:0] len, n;
    logic stop;
    len  = layout_len(w[31:26]);
    n    = '0;
    stop = 1'b0;
    for (int k = 0; k < NSLOT; k++) begin
      if (!stop && CW'(k) < len) begin
        if (slot_field(w, CW'(k)) == '0) stop = 1'b1;
        else n = CW'(k + 1);
      end else begin
        stop = 1'b1;
      end
    end
    return n;
  endfunction

  function automatic pbind_t param_for(input logic [31:0] w, input logic [CW-1:0] k);
    logic [5:0]    op;
    logic          has1, has2;
    logic [CW-1:0] s1, s2;
    pbind_t        b;
    op   = w[31:26];
    has1 = (op >= OP_S4P1) && (op <= OP_S2P2);
    has2 = (op == OP_S3P2) || (op == OP_S2P2);
    s1   = w[5] ? CW'(1) : CW'(0);
    s2   = (op == OP_S3P2) ? CW'(2) : (w[5] ? CW'(0) : CW'(1));
    b    = '0;
    if (has1 && k == s1)      b = '{hit: 1'b1, val: (op == OP_S4P1) ? w[4:0] : w[10:6]};
    else if (has2 && k == s2) b = '{hit: 1'b1, val: w[4:0]};
    return b;
  endfunction
endpackage

// File: rtl/pks_table.sv
module pks_table #(
  parameter int W        = 32,
  parameter int DEPTH    = 32,
  parameter bit ZERO_ROW = 1'b0,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    if (ZERO_ROW && r == 0) begin : g_fixed
      assign mem[r] = '0;
    end else begin : g_store
      always_ff @(posedge clk)
        if (we && wa == AW'(r)) mem[r] <= wd;
    end
  end

  assign rd = mem[ra];
endmodule

// File: rtl/pks_slot_ctrl.sv
module pks_slot_ctrl
  import pks_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [31:0]   fetch_word,
  input  logic          stall,
  input  logic          flush,
  input  logic          commit,
  input  logic          trap,
  output logic          ready,
  output logic          issue,
  output logic [31:0]   word_q,
  output logic [CW-1:0] iptr_q,
  output logic [CW-1:0] dcnt_q
);
  logic          busy_q;
  logic [CW-1:0] ncnt_q;
  logic [CW-1:0] dcnt_nx;
  logic          accept;
  logic          commit_ok;

  assign ready     = !busy_q;
  assign accept    = ready && fetch_valid && !flush;
  assign issue     = busy_q && (iptr_q < ncnt_q) && !stall;
  assign commit_ok = commit && (dcnt_q < iptr_q);
  assign dcnt_nx   = dcnt_q + CW'(commit_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      word_q <= '0;
      ncnt_q <= '0;
      iptr_q <= '0;
      dcnt_q <= '0;
    end else if (flush) begin
      busy_q <= 1'b0;
    end else if (accept) begin
      word_q <= fetch_word;
      ncnt_q <= eff_len(fetch_word);
      busy_q <= eff_len(fetch_word) != '0;
      iptr_q <= '0;
      dcnt_q <= '0;
    end else if (busy_q) begin
      dcnt_q <= dcnt_nx;
      if (trap)       iptr_q <= dcnt_nx;
      else if (issue) iptr_q <= iptr_q + CW'(1);
      if (dcnt_nx == ncnt_q) busy_q <= 1'b0;
    end
  end

  // R8
  stall_noissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !issue);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && stall && !trap && !flush |=> $stable(iptr_q));
  // R9
  flush_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ready);
  // R10
  done_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= iptr_q);
  // R11
  trap_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && trap && !flush |=> !issue || iptr_q == dcnt_q);
endmodule

// File: rtl/pack_slot_seq.sv
module pack_slot_seq
  import pks_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [31:0]     fetch_word,
  output logic            ready,
  input  logic            stall,
  input  logic            flush,
  input  logic            commit,
  input  logic            trap,
  output logic            iss_valid,
  output logic [XLEN-1:0] iss_instr,
  output logic [XLEN-1:0] iss_imm,
  output logic [2:0]      iss_slot,
  output logic [2:0]      done_cnt,
  input  logic            ent_we,
  input  logic [4:0]      ent_idx,
  input  logic [XLEN-1:0] ent_instr,
  input  logic [XLEN-1:0] ent_imm,
  input  logic            ent_branch,
  input  logic            tab_we,
  input  logic [4:0]      tab_idx,
  input  logic [XLEN-1:0] tab_val
);
  localparam int NENT = 1 << FW;
  localparam int EW   = 2 * XLEN + 1;

  function automatic logic [XLEN-1:0] sext_disp(input logic [FW-1:0] d);
    return {{(XLEN-FW){d[FW-1]}}, d};
  endfunction

  logic [31:0]     word_q;
  logic [CW-1:0]   iptr_q, dcnt_q;
  logic [FW-1:0]   rd_idx;
  pbind_t          bind_w;
  logic [EW-1:0]   ent_row;
  logic [XLEN-1:0] tab_rd;
  logic            row_branch;
  logic [XLEN-1:0] row_instr, row_imm;

  pks_slot_ctrl u_ctrl (
    .clk, .rst_n, .fetch_valid, .fetch_word, .stall, .flush, .commit, .trap,
    .ready, .issue(iss_valid), .word_q, .iptr_q, .dcnt_q
  );

  assign rd_idx = slot_field(word_q, iptr_q);
  assign bind_w = param_for(word_q, iptr_q);

  pks_table #(.W(EW), .DEPTH(NENT), .ZERO_ROW(1'b1)) u_entries (
    .clk, .we(ent_we), .wa(ent_idx), .wd({ent_branch, ent_imm, ent_instr}),
    .ra(rd_idx), .rd(ent_row)
  );

  pks_table #(.W(XLEN), .DEPTH(NENT), .ZERO_ROW(1'b0)) u_immtab (
    .clk, .we(tab_we), .wa(tab_idx), .wd(tab_val), .ra(bind_w.val), .rd(tab_rd)
  );

  assign {row_branch, row_imm, row_instr} = ent_row;

  always_comb begin
    if (!bind_w.hit)     iss_imm = row_imm;
    else if (row_branch) iss_imm = sext_disp(bind_w.val);
    else                 iss_imm = tab_rd;
  end

  assign iss_instr = row_instr;
  assign iss_slot  = iptr_q;
  assign done_cnt  = dcnt_q;

  // R3
  no_empty_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> rd_idx != '0);
  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_slot < CW'(NSLOT));
  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !trap && !flush && !ready |=> ready || iss_slot == $past(iss_slot) + 3'd1);
endmodule

// File: tb/tb_pack_slot_seq.sv
module tb_pack_slot_seq;
  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0, stall = 0, flush = 0, commit = 0, trap = 0;
  logic [31:0] fetch_word = 0;
  logic ready, iss_valid;
  logic [31:0] iss_instr, iss_imm;
  logic [2:0] iss_slot, done_cnt;
  logic ent_we = 0, ent_branch = 0, tab_we = 0;
  logic [4:0] ent_idx = 0, tab_idx = 0;
  logic [31:0] ent_instr = 0, ent_imm = 0, tab_val = 0;

  int checks = 0, errors = 0;
  string cur_tag = "R2";

  logic [31:0] m_ins [32];
  logic [31:0] m_def [32];
  logic        m_br  [32];
  logic [31:0] m_tab [32];
  logic        m_busy = 0;
  logic [31:0] m_word = 0;
  int          m_n = 0, m_ptr = 0, m_done = 0;

  always #10 clk = ~clk;

  pack_slot_seq dut (.*);

  function automatic int fld(logic [31:0] w, int k);
    int pos[5] = '{21, 16, 11, 6, 0};
    return int'((w >> pos[k]) & 32'h1f);
  endfunction

  function automatic int lay(logic [5:0] op);
    if (op == 6'h20) return 5;
    if (op == 6'h21 || op == 6'h24) return 4;
    if (op == 6'h22 || op == 6'h25 || op == 6'h26) return 3;
    if (op == 6'h23 || op == 6'h27 || op == 6'h28) return 2;
    return 0;
  endfunction

  function automatic int usable(logic [31:0] w);
    int c = 0;
    while (c < lay(w[31:26]) && fld(w, c) != 0) c++;
    return c;
  endfunction

  // returns -1 when no parameter is bound to slot k
  function automatic int bound(logic [31:0] w, int k);
    int op = int'(w[31:26]);
    int f = int'(w[5]);
    int first_slot = f;
    int second_slot;
    if (op < 'h24 || op > 'h28) return -1;
    if (k == first_slot) return (op == 'h24) ? fld(w, 4) : fld(w, 3);
    if (op == 'h26 || op == 'h28) begin
      second_slot = (op == 'h26) ? 2 : 1 - f;
      if (k == second_slot) return fld(w, 4);
    end
    return -1;
  endfunction

  function automatic logic [31:0] exp_imm(logic [31:0] w, int k);
    int i = fld(w, k);
    int p = bound(w, k);
    if (p < 0) return m_def[i];
    if (m_br[i]) return (p >= 16) ? 32'(p - 32) : 32'(p);
    return m_tab[p];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    logic ev;
    #2;
    ev = m_busy && (m_ptr < m_n) && !stall;
    chk(cur_tag, 32'(ready), 32'(!m_busy), "ready");
    chk(cur_tag, 32'(done_cnt), 32'(m_done), "done_cnt");
    chk(stall ? "R8" : cur_tag, 32'(iss_valid), 32'(ev), "iss_valid");
    if (ev && iss_valid) begin
      chk(cur_tag, 32'(iss_slot), 32'(m_ptr), "iss_slot");
      chk(cur_tag, iss_instr, m_ins[fld(m_word, m_ptr)], "iss_instr");
      chk(cur_tag, iss_imm, exp_imm(m_word, m_ptr), "iss_imm");
    end
    @(posedge clk);
    if (ent_we && ent_idx != 0) begin
      m_ins[ent_idx] = ent_instr; m_def[ent_idx] = ent_imm; m_br[ent_idx] = ent_branch;
    end
    if (tab_we) m_tab[tab_idx] = tab_val;
    if (flush) m_busy = 0;
    else if (!m_busy) begin
      if (fetch_valid) begin
        m_word = fetch_word; m_n = usable(fetch_word);
        m_busy = m_n > 0; m_ptr = 0; m_done = 0;
      end
    end else begin
      if (commit && m_done < m_ptr) m_done++;
      if (trap) m_ptr = m_done;
      else if (ev) m_ptr++;
      if (m_done == m_n) m_busy = 0;
    end
    @(negedge clk);
  endtask

  task automatic offer(logic [31:0] w);
    fetch_word = w; fetch_valid = 1; cyc(); fetch_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 30 && m_busy; i++) cyc();
    cyc();
  endtask

  function automatic logic [31:0] mk(logic [5:0] op, int a, int b, int c, int d, int fl, int e);
    return {op, 5'(a), 5'(b), 5'(c), 5'(d), 1'(fl), 5'(e)};
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_ins[i] = 0; m_def[i] = 0; m_br[i] = 0; m_tab[i] = 0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1;
    cur_tag = "R10"; cyc();                         // reset state: ready, nothing issued
    cur_tag = "R12";
    for (int i = 1; i < 32; i++) begin
      ent_we = 1; ent_idx = 5'(i); ent_instr = 32'hA000_0000 | i;
      ent_imm = 32'(i * 3 + 100); ent_branch = (i == 7 || i == 9);
      tab_we = 1; tab_idx = 5'(i); tab_val = 32'h5000 + i * 17;
      cyc();
    end
    tab_idx = 0; tab_val = 32'h0000_0FEE; ent_we = 0; cyc();
    tab_we = 0;
    commit = 1;
    cur_tag = "R1";  offer(mk(6'h20, 1, 2, 3, 4, 1, 5)); drain();    // five slots
    cur_tag = "R7";  offer(mk(6'h22, 11, 12, 13, 30, 0, 31)); drain(); // default immediates
    cur_tag = "R3";  offer(mk(6'h21, 5, 6, 0, 8, 0, 0)); drain();    // stop at empty slot
    cur_tag = "R3";  offer(mk(6'h20, 0, 2, 3, 4, 0, 5)); drain();    // nothing issuable
    cur_tag = "R1";  offer(mk(6'h3F, 1, 2, 3, 4, 0, 5)); drain();    // unknown code
    cur_tag = "R5";  offer(mk(6'h24, 2, 3, 4, 5, 1, 6)); drain();    // R4 flag=1 -> slot 1
    cur_tag = "R6";  offer(mk(6'h26, 3, 4, 7, 2, 0, 19)); drain();   // branch displacement -13
    cur_tag = "R6";  offer(mk(6'h25, 9, 4, 5, 15, 0, 0)); drain();   // +15 on branch
    cur_tag = "R4";  offer(mk(6'h28, 6, 8, 0, 0, 1, 10)); drain();   // p1 slot1, p2 slot0
    cur_tag = "R4";  offer(mk(6'h27, 12, 13, 0, 21, 0, 0)); drain();
    cur_tag = "R8";  offer(mk(6'h20, 1, 2, 3, 4, 0, 5));
    cyc(); stall = 1; cyc(); cyc(); cyc(); stall = 0; drain();
    cur_tag = "R9";  offer(mk(6'h20, 1, 2, 3, 4, 0, 5));
    cyc(); cyc(); flush = 1; cyc(); flush = 0; cyc(); drain();
    cur_tag = "R11"; commit = 0; offer(mk(6'h20, 1, 2, 3, 4, 0, 5));
    cyc(); cyc(); cyc(); commit = 1; cyc(); commit = 0; trap = 1; cyc(); trap = 0;
    cyc(); commit = 1; drain();
    cur_tag = "R10"; commit = 0; offer(mk(6'h23, 14, 15, 0, 0, 0, 0));
    cyc(); cyc(); cyc(); cyc(); commit = 1; drain();
    cur_tag = "R12";
    ent_we = 1; ent_idx = 3; ent_instr = 32'hBEEF_0003; ent_imm = 32'h77; ent_branch = 0;
    offer(mk(6'h22, 3, 1, 3, 0, 0, 0));
    ent_we = 0; drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule